// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple single-cycle register port. A 16-bit down-counter is advanced by a tick built in two stages: an 8-bit programmable prescaler, followed by a fixed power-of-two divider whose ratio comes from a 2-bit select. When the counter steps from one to zero the timer has expired. Depending on two independent enable bits, expiry starts a fixed-length active-high reset pulse, sets a sticky interrupt flag, does both, or does neither. On the next tick the counter reloads from a separate reload register and keeps counting.

Software keeps the system alive by rewriting the count register before it runs out. That write also restarts the prescaler and the divider, so every keep-alive buys a full timeout. Before turning the timer on, software normally writes the reload and count registers, then sets the run bit. For a timeout of T seconds at an input clock of F Hz, the count to program is T * F / ((prescale + 1) * divide ratio).

Top module: `presc_wdog`

## Requirements
- R1: After reset the control register reads 0xFF1D (run on, reset action on, interrupt action off, divide select 3, prescale 255). The reload and count registers both read 0x8000. The flag register reads 0, and the reset and interrupt outputs are low.
- R2: Register index 0 is control, 1 is reload, 2 is count and 3 is the flag (bit 0). In control, bit 0 is run, bit 1 is interrupt-on-expiry, bit 2 is reset-on-expiry, bits 4:3 are the divide select and bits 15:8 are the prescale value minus one. Bits 7:5 of control read as 0. Other written fields read back unchanged.
- R3: While running, a tick occurs every (prescale+1) * (16 << select) clock cycles, so select values 0 to 3 give divide ratios of 16, 32, 64 and 128. The count drops by one on each tick.
- R4: A write to the count register loads the counter on that clock edge and restarts the prescaler and divider, so the next expiry comes a full timeout later.
- R5: Expiry is the tick that takes the count from 1 to 0. The following tick loads the count from the reload register, and counting continues from there.
- R6: With reset-on-expiry set, the reset output goes high in the cycle after the expiry edge and stays high for exactly 128 clock cycles.
- R7: With interrupt-on-expiry set, expiry sets the flag and the interrupt output follows it. The flag stays set until a write with bit 0 set to index 3. A write of 0 to index 3 leaves the flag set.
- R8: The two actions are independent. With only the reset action enabled, expiry leaves the flag clear. With only the interrupt action enabled, expiry gives no reset pulse.
- R9: With run cleared the count holds its value, no expiry occurs and no reset is issued.
- R10: A write to the reload register does not change the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 2 | Register index |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the indexed register (combinational) |
| wdt_rst_o | output | 1 | Active-high system reset pulse |
| wdt_irq_o | output | 1 | Interrupt request, level of the sticky flag |

## Verification
The bound checker checks the following on every cycle: that the count decrements only on ticks, holds while stopped, loads on count writes and reloads after reaching zero; that a reset pulse starts only after an enabled expiry; and that the flag stays set until it is cleared. Some behaviour can only be shown by the bench's directed scenarios, which measure it cycle by cycle against the programmed values. That covers the tick period for each prescale and select value, the exact 128-cycle pulse width, the keep-alive restart and the register layout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_RELOAD = 2'd1,
      REG_COUNT  = 2'd2,
      REG_FLAG   = 2'd3
   } wdg_reg_e;

   localparam int CTRL_RUN_BIT   = 0;
   localparam int CTRL_IRQEN_BIT = 1;
   localparam int CTRL_RSTEN_BIT = 2;
   localparam int CTRL_SEL_LSB   = 3;
   localparam int CTRL_PSC_LSB   = 8;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PSC_W  = 8,
   parameter int SEL_W  = 2,
   parameter logic [DATA_W-1:0] CTRL_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cnt_val,
   input  logic [DATA_W-1:0] reload_val,
   input  logic              expire,
   output logic              run,
   output logic              irq_en,
   output logic              rst_en,
   output logic [SEL_W-1:0]  sel,
   output logic [PSC_W-1:0]  psc,
   output logic              reload_we,
   output logic              cnt_we,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_flag
);
   localparam logic [DATA_W-1:0] CTRL_MASK =
      DATA_W'(7)
      | (DATA_W'((1 << SEL_W) - 1) << CTRL_SEL_LSB)
      | (DATA_W'((1 << PSC_W) - 1) << CTRL_PSC_LSB);

   logic [DATA_W-1:0] ctrl_q;
   logic              ctrl_we;
   logic              flag_clr;

   assign ctrl_we   = wr && (addr == REG_CTRL);
   assign reload_we = wr && (addr == REG_RELOAD);
   assign cnt_we    = wr && (addr == REG_COUNT);
   assign flag_clr  = wr && (addr == REG_FLAG) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else if (ctrl_we) begin
         ctrl_q <= wdata & CTRL_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag <= 1'b0;
      end else if (expire && irq_en) begin
         irq_flag <= 1'b1;
      end else if (flag_clr) begin
         irq_flag <= 1'b0;
      end
   end

   assign run    = ctrl_q[CTRL_RUN_BIT];
   assign irq_en = ctrl_q[CTRL_IRQEN_BIT];
   assign rst_en = ctrl_q[CTRL_RSTEN_BIT];
   assign sel    = ctrl_q[CTRL_SEL_LSB +: SEL_W];
   assign psc    = ctrl_q[CTRL_PSC_LSB +: PSC_W];

   always_comb begin
      case (wdg_reg_e'(addr))
         REG_CTRL:   rdata = ctrl_q;
         REG_RELOAD: rdata = reload_val;
         REG_COUNT:  rdata = cnt_val;
         default:    rdata = {{(DATA_W-1){1'b0}}, irq_flag};
      endcase
   end
endmodule

// File: rtl/wdg_clkdiv.sv
module wdg_clkdiv #(
   parameter int PSC_W     = 8,
   parameter int SEL_W     = 2,
   parameter int BASE_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] psc,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = BASE_LOG2 + (1 << SEL_W) - 1;

   logic [PSC_W-1:0] pre_cnt;
   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W:0]   lim_full;
   logic [DIV_W-1:0] div_lim;
   logic             pre_hit;
   logic             div_hit;

   assign lim_full = (DIV_W+1)'(1) << (BASE_LOG2 + int'(sel));
   assign div_lim  = DIV_W'(lim_full - (DIV_W+1)'(1));
   assign pre_hit  = (pre_cnt >= psc);
   assign div_hit  = (div_cnt >= div_lim);
   assign tick     = run && !restart && pre_hit && div_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (!run || restart) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (pre_hit) begin
         pre_cnt <= '0;
         div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] CNT_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic              reload_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cnt,
   output logic [DATA_W-1:0] reload,
   output logic              expire
);
   assign expire = tick && !load && (cnt == DATA_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload <= CNT_RST;
      end else if (reload_we) begin
         reload <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CNT_RST;
      end else if (load) begin
         cnt <= wdata;
      end else if (tick) begin
         cnt <= (cnt == '0) ? reload : cnt - 1'b1;
      end
   end
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
   parameter int RST_CYCLES = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   generate
      if (RST_CYCLES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse <= 1'b0;
            else        pulse <= fire;
         end
      end else begin : g_count
         localparam int LEN_W = $clog2(RST_CYCLES + 1);
         logic [LEN_W-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             left_q <= '0;
            else if (fire)          left_q <= LEN_W'(RST_CYCLES);
            else if (left_q != '0)  left_q <= left_q - 1'b1;
         end
         assign pulse = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/presc_wdog.sv
module presc_wdog
   import wdg_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int PSC_W      = 8,
   parameter int SEL_W      = 2,
   parameter int BASE_LOG2  = 4,
   parameter int RST_CYCLES = 128
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_wr_i,
   input  logic [1:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              wdt_rst_o,
   output logic              wdt_irq_o
);
   localparam logic [DATA_W-1:0] CTRL_RST =
      (DATA_W'((1 << PSC_W) - 1) << CTRL_PSC_LSB)
      | (DATA_W'((1 << SEL_W) - 1) << CTRL_SEL_LSB)
      | (DATA_W'(1) << CTRL_RSTEN_BIT)
      | (DATA_W'(1) << CTRL_RUN_BIT);
   localparam logic [DATA_W-1:0] CNT_RST = DATA_W'(1) << (DATA_W - 1);

   generate
      if (CTRL_SEL_LSB + SEL_W > CTRL_PSC_LSB) begin : g_bad_sel
         $error("divide select field overlaps prescale field");
      end
      if (CTRL_PSC_LSB + PSC_W > DATA_W) begin : g_bad_psc
         $error("prescale field exceeds register width");
      end
      if (RST_CYCLES < 1) begin : g_bad_len
         $error("reset pulse length must be at least one cycle");
      end
   endgenerate

   logic              run, irq_en, rst_en;
   logic [SEL_W-1:0]  sel;
   logic [PSC_W-1:0]  psc;
   logic              reload_we, cnt_we;
   logic              tick, expire;
   logic [DATA_W-1:0] cnt, reload;

   wdg_regs #(
      .DATA_W(DATA_W), .PSC_W(PSC_W), .SEL_W(SEL_W), .CTRL_RST(CTRL_RST)
   ) regs_i (
      .clk(clk_i), .rst_n(rst_ni), .wr(bus_wr_i), .addr(bus_addr_i),
      .wdata(bus_wdata_i), .cnt_val(cnt), .reload_val(reload),
      .expire(expire), .run(run), .irq_en(irq_en), .rst_en(rst_en),
      .sel(sel), .psc(psc), .reload_we(reload_we), .cnt_we(cnt_we),
      .rdata(bus_rdata_o), .irq_flag(wdt_irq_o)
   );

   wdg_clkdiv #(
      .PSC_W(PSC_W), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)
   ) div_i (
      .clk(clk_i), .rst_n(rst_ni), .run(run), .restart(cnt_we),
      .psc(psc), .sel(sel), .tick(tick)
   );

   wdg_counter #(
      .DATA_W(DATA_W), .CNT_RST(CNT_RST)
   ) cnt_i (
      .clk(clk_i), .rst_n(rst_ni), .tick(tick), .load(cnt_we),
      .reload_we(reload_we), .wdata(bus_wdata_i), .cnt(cnt),
      .reload(reload), .expire(expire)
   );

   wdg_rst_pulse #(
      .RST_CYCLES(RST_CYCLES)
   ) pulse_i (
      .clk(clk_i), .rst_n(rst_ni), .fire(expire && rst_en), .pulse(wdt_rst_o)
   );
endmodule

// File: rtl/presc_wdog_chk.sv
module presc_wdog_chk
   import wdg_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic              run,
   input logic              rst_en,
   input logic              irq_en,
   input logic              tick,
   input logic              expire,
   input logic [DATA_W-1:0] cnt,
   input logic [DATA_W-1:0] reload,
   input logic              rst_out,
   input logic              irq_out
);
   logic cnt_wr, flag_clr;
   assign cnt_wr   = wr && (addr == REG_COUNT);
   assign flag_clr = wr && (addr == REG_FLAG) && wdata[0];

   AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt == $past(wdata)); // R4
   AST_COUNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R3
   AST_COUNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && cnt == '0) |=> cnt == $past(reload)); // R5
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt)); // R9
   AST_RST_FOLLOWS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && rst_en) |=> rst_out); // R6
   AST_RST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out) |-> $past(expire && rst_en)); // R8
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !flag_clr) |=> irq_out); // R7
   AST_IRQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(expire && irq_en)); // R8
endmodule

bind presc_wdog presc_wdog_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk_i), .rst_n(rst_ni), .wr(bus_wr_i), .addr(bus_addr_i),
   .wdata(bus_wdata_i), .run(run), .rst_en(rst_en), .irq_en(irq_en),
   .tick(tick), .expire(expire), .cnt(cnt), .reload(reload),
   .rst_out(wdt_rst_o), .irq_out(wdt_irq_o)
);

// File: tb/presc_wdog_tb_top.sv
`timescale 1ns/1ps
module presc_wdog_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        wdt_rst, wdt_irq;
   int n_checks = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   presc_wdog dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .wdt_rst_o(wdt_rst), .wdt_irq_o(wdt_irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic t_reset_state();
      logic [15:0] v;
      rd(2'd0, v); chk("R1", "ctrl", v, 16'hFF1D);
      rd(2'd1, v); chk("R1", "reload", v, 16'h8000);
      rd(2'd2, v); chk("R1", "count", v, 16'h8000);
      rd(2'd3, v); chk("R1", "flag", v, 16'h0000);
      chk("R1", "rst out", wdt_rst, 1'b0);
      chk("R1", "irq out", wdt_irq, 1'b0);
   endtask

   task automatic t_regmap();
      logic [15:0] v;
      wr(2'd0, 16'hFFFF);
      rd(2'd0, v); chk("R2", "ctrl masked readback", v, 16'hFF1F);
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h1234);
      rd(2'd1, v); chk("R2", "reload readback", v, 16'h1234);
      wr(2'd2, 16'h0007);
      wr(2'd1, 16'h0009);
      rd(2'd2, v); chk("R10", "count after reload write", v, 16'h0007);
      rd(2'd1, v); chk("R10", "reload value", v, 16'h0009);
   endtask

   // reset-only action, expiry, reload, pulse width
   task automatic t_reset_action();
      logic [15:0] v;
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'd20);
      wr(2'd2, 16'd2);
      wr(2'd0, 16'h0005);
      step(31);
      rd(2'd2, v); chk("R3", "count before expiry", v, 16'd1);
      chk("R6", "rst before expiry", wdt_rst, 1'b0);
      step(1);
      rd(2'd2, v); chk("R5", "count at expiry", v, 16'd0);
      chk("R6", "rst after expiry", wdt_rst, 1'b1);
      chk("R8", "irq stays low", wdt_irq, 1'b0);
      step(16);
      rd(2'd2, v); chk("R5", "count reloaded", v, 16'd20);
      step(16);
      rd(2'd2, v); chk("R5", "count continues", v, 16'd19);
      step(95);
      chk("R6", "rst last cycle", wdt_rst, 1'b1);
      step(1);
      chk("R6", "rst ended after 128", wdt_rst, 1'b0);
      wr(2'd0, 16'h0000);
   endtask

   task automatic t_irq_action();
      logic [15:0] v;
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'd100);
      wr(2'd2, 16'd1);
      wr(2'd0, 16'h0003);
      step(15);
      chk("R7", "irq before expiry", wdt_irq, 1'b0);
      step(1);
      chk("R7", "irq at expiry", wdt_irq, 1'b1);
      chk("R8", "no rst with irq only", wdt_rst, 1'b0);
      rd(2'd3, v); chk("R7", "flag read", v, 16'd1);
      step(20);
      chk("R7", "irq sticky", wdt_irq, 1'b1);
      wr(2'd3, 16'd0);
      chk("R7", "write 0 keeps flag", wdt_irq, 1'b1);
      wr(2'd3, 16'd1);
      chk("R7", "write 1 clears flag", wdt_irq, 1'b0);
      chk("R8", "still no rst", wdt_rst, 1'b0);
      wr(2'd0, 16'h0000);
   endtask

   task automatic t_dividers();
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h1000);
      wr(2'd2, 16'd1);
      wr(2'd0, 16'h001D);      // select 3 -> 128 cycles per tick
      step(127);
      chk("R3", "select3 before tick", wdt_rst, 1'b0);
      step(1);
      chk("R3", "select3 expiry at 128", wdt_rst, 1'b1);
      wr(2'd0, 16'h0000);
      step(130);
      wr(2'd2, 16'd1);
      wr(2'd0, 16'h0205);      // prescale 2 -> 3*16 = 48 cycles per tick
      step(47);
      chk("R3", "prescale before tick", wdt_rst, 1'b0);
      step(1);
      chk("R3", "prescale expiry at 48", wdt_rst, 1'b1);
      wr(2'd0, 16'h0000);
      step(130);
   endtask

   task automatic t_keepalive();
      logic [15:0] v;
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h1000);
      wr(2'd2, 16'd2);
      wr(2'd0, 16'h0005);
      step(20);
      rd(2'd2, v); chk("R3", "count after one tick", v, 16'd1);
      wr(2'd2, 16'd2);
      step(31);
      chk("R4", "no rst before restarted timeout", wdt_rst, 1'b0);
      rd(2'd2, v); chk("R4", "count restarted", v, 16'd1);
      step(1);
      chk("R4", "rst after full restarted timeout", wdt_rst, 1'b1);
      wr(2'd0, 16'h0000);
      step(130);
   endtask

   task automatic t_stopped();
      logic [15:0] v;
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'd1);
      wr(2'd0, 16'h0005);
      step(10);
      wr(2'd0, 16'h0004);
      step(300);
      rd(2'd2, v); chk("R9", "count held", v, 16'd1);
      chk("R9", "no rst while stopped", wdt_rst, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_regmap();
      t_reset_action();
      t_irq_action();
      t_dividers();
      t_keepalive();
      t_stopped();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule